// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block performs the eight integer multiply and divide operations of a 32-bit RISC-V core's M extension over several clock cycles. A request is a one-cycle start strobe carrying an operation code and two operands. The unit then holds its busy output high, and the pipeline uses busy as its stall. When the answer is ready the unit drops busy and pulses done for one cycle with the result on its output.

Multiplication adds shifted copies of the first operand, one bit of the second operand per cycle. The low-word product stops as soon as no set bits remain in the second operand. The high-word products always take one cycle per operand bit. Division is restoring long division on operand magnitudes, padded to a fixed latency. A zero divisor is detected when the request is accepted and finishes after one busy cycle. Signed operands are turned into magnitudes on entry, and the sign of the result is restored on exit.

Top module: `imd_unit`

## Requirements
- R1: The operation code selects, by value: 0 low-word product, 1 high word signed×signed, 2 high word signed×unsigned (first operand signed), 3 high word unsigned×unsigned, 4 signed quotient, 5 unsigned quotient, 6 signed remainder, 7 unsigned remainder. Code 0 returns the low XLEN bits of the product.
- R2: Codes 1, 2 and 3 return the upper XLEN bits of the 2·XLEN-bit product, with each operand read as signed or unsigned as R1 gives.
- R3: For a nonzero divisor, codes 4 and 5 return the quotient truncated toward zero, and codes 6 and 7 return a remainder that takes the sign of the dividend.
- R4: Code 0 keeps busy high for max(1, n) cycles, where n is the position of the highest set bit of the second operand plus one.
- R5: Codes 1, 2 and 3 keep busy high for exactly XLEN cycles.
- R6: Codes 4 to 7 with a nonzero divisor keep busy high for XLEN + DIV_PAD cycles (37 by default).
- R7: Codes 4 to 7 with a zero divisor keep busy high for one cycle. Codes 4 and 5 then return all ones, and codes 6 and 7 return the dividend.
- R8: For a signed divide of the most negative value by -1, code 4 returns the dividend and code 6 returns zero.
- R9: After reset, busy, done and the result are zero. A start accepted while idle raises busy in the next cycle. Done is a one-cycle pulse that comes in the same cycle busy falls, and the result stays on the output until the next completion.
- R10: A start strobe while busy is ignored, and the running operation keeps its result and its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| op_i | input | 3 | Operation code (see R1) |
| opa_i | input | XLEN | First operand (multiplicand / dividend) |
| opb_i | input | XLEN | Second operand (multiplier / divisor) |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | XLEN | Result of the last completed operation |

## Verification
The bench builds the unit with XLEN = 4 and the default DIV_PAD of 5. At that width every operation code can be run against all 256 operand pairs. That covers every early-stop length of the low-word product, every zero divisor, the lone signed-overflow pair, and every sign combination for the high-word products and the remainders. Each result and each busy count is compared with arithmetic done in the bench. A second sweep sends a start with different operands in the first busy cycle, to show that the running operation is unaffected.

// File: rtl/imd_pkg.sv
package imd_pkg;

  typedef enum logic [2:0] {
    IMD_MUL    = 3'd0,
    IMD_MULH   = 3'd1,
    IMD_MULHSU = 3'd2,
    IMD_MULHU  = 3'd3,
    IMD_DIV    = 3'd4,
    IMD_DIVU   = 3'd5,
    IMD_REM    = 3'd6,
    IMD_REMU   = 3'd7
  } imd_op_e;

  function automatic logic is_div_op(imd_op_e op);
    return op[2];
  endfunction

  function automatic logic wants_rem(imd_op_e op);
    return (op == IMD_REM) || (op == IMD_REMU);
  endfunction

  function automatic logic a_is_signed(imd_op_e op);
    return (op == IMD_MULH) || (op == IMD_MULHSU) || (op == IMD_DIV) || (op == IMD_REM);
  endfunction

  function automatic logic b_is_signed(imd_op_e op);
    return (op == IMD_MULH) || (op == IMD_DIV) || (op == IMD_REM);
  endfunction

endpackage

// File: rtl/imd_prep.sv
module imd_prep
  import imd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  imd_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg_main,
  output logic            neg_rem,
  output logic            b_zero
);
  logic sa, sb;

  always_comb begin
    sa       = a_is_signed(op) & a[XLEN-1];
    sb       = b_is_signed(op) & b[XLEN-1];
    mag_a    = sa ? (~a + 1'b1) : a;
    mag_b    = sb ? (~b + 1'b1) : b;
    neg_main = sa ^ sb;
    neg_rem  = sa;
    b_zero   = (b == '0);
  end
endmodule

// File: rtl/imd_mul_step.sv
module imd_mul_step #(
  parameter int unsigned XLEN = 32
) (
  input  logic [2*XLEN-1:0] acc,
  input  logic [2*XLEN-1:0] mcand,
  input  logic [XLEN-1:0]   mplier,
  output logic [2*XLEN-1:0] acc_n,
  output logic [2*XLEN-1:0] mcand_n,
  output logic [XLEN-1:0]   mplier_n
);
  always_comb begin
    acc_n    = mplier[0] ? (acc + mcand) : acc;
    mcand_n  = mcand << 1;
    mplier_n = mplier >> 1;
  end
endmodule

// File: rtl/imd_div_step.sv
module imd_div_step #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] rem,
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] dvsr,
  output logic [XLEN-1:0] rem_n,
  output logic [XLEN-1:0] quo_n
);
  logic [XLEN:0] trial;

  always_comb begin
    trial = {rem, quo[XLEN-1]} - {1'b0, dvsr};
    if (!trial[XLEN]) begin
      rem_n = trial[XLEN-1:0];
      quo_n = {quo[XLEN-2:0], 1'b1};
    end else begin
      rem_n = {rem[XLEN-2:0], quo[XLEN-1]};
      quo_n = {quo[XLEN-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/imd_unit.sv
module imd_unit
  import imd_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned DIV_PAD = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  localparam int unsigned DIV_LAT = XLEN + DIV_PAD;
  localparam int unsigned CW      = $clog2(DIV_LAT + 1);

  // control state (reset)
  logic            busy_q, busy_d, done_q, done_d;
  logic [XLEN-1:0] res_q, res_d;
  imd_op_e         op_q, op_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  // datapath state (enabled, no reset)
  logic [2*XLEN-1:0] acc_q, acc_d, mcand_q, mcand_d;
  logic [XLEN-1:0]   mplier_q, mplier_d, rem_q, rem_d, quo_q, quo_d;
  logic [XLEN-1:0]   dvsr_q, dvsr_d, dvd_q, dvd_d;
  logic              negm_q, negm_d, negr_q, negr_d, bz_q, bz_d;

  logic              load_en, dp_en;
  logic [XLEN-1:0]   mag_a, mag_b;
  logic              neg_main, neg_rem, b_zero;
  logic [2*XLEN-1:0] mul_acc_n, mul_mcand_n, mul_fix;
  logic [XLEN-1:0]   mul_mplier_n, div_rem_n, div_quo_n;
  logic              last;
  logic [XLEN-1:0]   fin;

  assign load_en = start_i & ~busy_q;
  assign dp_en   = load_en | busy_q;

  imd_prep #(.XLEN(XLEN)) u_prep (
    .op(imd_op_e'(op_i)), .a(opa_i), .b(opb_i),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_main(neg_main), .neg_rem(neg_rem), .b_zero(b_zero)
  );

  imd_mul_step #(.XLEN(XLEN)) u_mul (
    .acc(acc_q), .mcand(mcand_q), .mplier(mplier_q),
    .acc_n(mul_acc_n), .mcand_n(mul_mcand_n), .mplier_n(mul_mplier_n)
  );

  imd_div_step #(.XLEN(XLEN)) u_div (
    .rem(rem_q), .quo(quo_q), .dvsr(dvsr_q),
    .rem_n(div_rem_n), .quo_n(div_quo_n)
  );

  assign mul_fix = negm_q ? (~mul_acc_n + 1'b1) : mul_acc_n;

  // next-state logic
  always_comb begin
    busy_d   = busy_q;
    done_d   = 1'b0;
    res_d    = res_q;
    op_d     = op_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    rem_d    = rem_q;
    quo_d    = quo_q;
    dvsr_d   = dvsr_q;
    dvd_d    = dvd_q;
    negm_d   = negm_q;
    negr_d   = negr_q;
    bz_d     = bz_q;
    last     = 1'b0;
    fin      = res_q;
    if (load_en) begin
      busy_d   = 1'b1;
      cnt_d    = '0;
      op_d     = imd_op_e'(op_i);
      acc_d    = '0;
      mcand_d  = {{XLEN{1'b0}}, mag_a};
      mplier_d = mag_b;
      rem_d    = '0;
      quo_d    = mag_a;
      dvsr_d   = mag_b;
      dvd_d    = opa_i;
      negm_d   = neg_main;
      negr_d   = neg_rem;
      bz_d     = b_zero;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (!is_div_op(op_q)) begin
        acc_d    = mul_acc_n;
        mcand_d  = mul_mcand_n;
        mplier_d = mul_mplier_n;
        if (op_q == IMD_MUL) begin
          last = (mul_mplier_n == '0);
          fin  = mul_acc_n[XLEN-1:0];
        end else begin
          last = (cnt_q == CW'(XLEN - 1));
          fin  = mul_fix[2*XLEN-1:XLEN];
        end
      end else if (bz_q) begin
        last = 1'b1;
        fin  = wants_rem(op_q) ? dvd_q : '1;
      end else begin
        if (cnt_q < CW'(XLEN)) begin
          rem_d = div_rem_n;
          quo_d = div_quo_n;
        end
        last = (cnt_q == CW'(DIV_LAT - 1));
        if (wants_rem(op_q)) fin = negr_q ? (~rem_q + 1'b1) : rem_q;
        else                 fin = negm_q ? (~quo_q + 1'b1) : quo_q;
      end
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_d  = fin;
      end
    end
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
      op_q   <= IMD_MUL;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      res_q  <= res_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
    end
  end

  // datapath registers with clock enable
  always_ff @(posedge clk_i) begin
    if (dp_en) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      rem_q    <= rem_d;
      quo_q    <= quo_d;
      dvsr_q   <= dvsr_d;
      dvd_q    <= dvd_d;
      negm_q   <= negm_d;
      negr_q   <= negr_d;
      bz_q     <= bz_d;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_FALL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9
  AST_BUSY_KEEPS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(op_q)); // R10
  AST_MUL_EARLY_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == IMD_MUL) |-> (mplier_q == '0)); // R4
  AST_HIGH_MUL_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !op_q[2] && op_q != IMD_MUL) |-> (cnt_q == CW'(XLEN))); // R5
  AST_DIV_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q[2] && !bz_q) |-> (cnt_q == CW'(DIV_LAT))); // R6
  AST_ZERO_DIV_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q[2] && bz_q) |-> (cnt_q == CW'(1))); // R7
endmodule

// File: tb/test_imd_unit.sv
module test_imd_unit;
  localparam int XL  = 4;
  localparam int PAD = 5;
  localparam int M   = (1 << XL) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op = '0;
  logic [XL-1:0] a = '0, b = '0;
  logic          busy, done;
  logic [XL-1:0] res;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  imd_unit #(.XLEN(XL), .DIV_PAD(PAD)) i_imd_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .opa_i(a), .opb_i(b), .busy_o(busy), .done_o(done), .result_o(res)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v >= (1 << (XL - 1))) ? v - (1 << XL) : v;
  endfunction

  function automatic bit ovf(int x, int y);
    return (sx(x) == -(1 << (XL - 1))) && (sx(y) == -1);
  endfunction

  function automatic int exp_res(int o, int x, int y);
    case (o)
      0: return (x * y) & M;
      1: return ((sx(x) * sx(y)) >>> XL) & M;
      2: return ((sx(x) * y) >>> XL) & M;
      3: return ((x * y) >> XL) & M;
      4: return (y == 0) ? M : ovf(x, y) ? x : (sx(x) / sx(y)) & M;
      5: return (y == 0) ? M : x / y;
      6: return (y == 0) ? x : ovf(x, y) ? 0 : (sx(x) % sx(y)) & M;
      default: return (y == 0) ? x : x % y;
    endcase
  endfunction

  function automatic int exp_lat(int o, int y);
    int n;
    n = 1;
    if (o == 0) begin
      for (int i = 0; i < XL; i++) if (y[i]) n = i + 1;
      return n;
    end
    if (o < 4) return XL;
    return (y == 0) ? 1 : XL + PAD;
  endfunction

  task automatic run_op(input int o, input int x, input int y, input bit poke);
    int n, guard;
    string rq, lq;
    op = 3'(o); a = XL'(x); b = XL'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    n = 0; guard = 0;
    while (!done && guard < 100) begin
      if (busy) n++;
      if (poke && n == 1 && guard == 0) begin
        start = 1'b1; op = ~op; a = ~a; b = ~b;
      end else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk(guard < 100, "watchdog op", guard, 0);
    chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    if (o == 0) begin rq = "R1"; lq = "R4"; end
    else if (o < 4) begin rq = "R2"; lq = "R5"; end
    else if (y == 0) begin rq = "R7"; lq = "R7"; end
    else begin rq = ovf(x, y) && (o == 4 || o == 6) ? "R8" : "R3"; lq = "R6"; end
    if (poke) begin rq = {"R10 ", rq}; lq = {"R10 ", lq}; end
    chk(int'(res) == exp_res(o, x, y), {rq, " result"}, int'(res), exp_res(o, x, y));
    chk(n == exp_lat(o, y), {lq, " latency"}, n, exp_lat(o, y));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R9 reset done", int'(done), 0);
    chk(res == '0, "R9 reset result", int'(res), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // exhaustive sweep R1..R8
    for (int o = 0; o < 8; o++)
      for (int x = 0; x <= M; x++)
        for (int y = 0; y <= M; y++)
          run_op(o, x, y, 1'b0);
    // done is a single pulse and the result is held (R9)
    run_op(4, 13, 3, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse width", int'(done), 0);
    chk(int'(res) == exp_res(4, 13, 3), "R9 result held", int'(res), exp_res(4, 13, 3));
    // start while busy ignored (R10)
    for (int o = 0; o < 8; o++)
      for (int x = 0; x <= M; x += 5)
        for (int y = 0; y <= M; y += 3)
          run_op(o, x, y, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule